// File: doc/BRIEF.md
# Timer Capture/Compare Channel

One timer channel that works in either of two modes, chosen by a mode bit. In capture mode it watches an input pin. The pin is first passed through a synchronizer. When the chosen edge arrives, the channel stores the value of one of two 16-bit time-base buses in its data register. In compare mode it compares that data register with the selected time-base bus on every cycle. On equality it loads a programmed level into an output flip-flop that drives the output pin.

A single level bit serves both modes. In capture mode it selects the edge polarity, and it is also copied into the output flip-flop on every cycle. When software switches the channel to compare mode, the pin therefore already holds the programmed level. Capture and match events both set a sticky flag, which raises an interrupt request when interrupts are enabled. A software force strobe drives the pin the same way a match does, but it leaves the flag alone.

Software reaches the channel through a simple port with two registers: the data register and a control/status register.

Top module: `tcc_chan`

## Requirements
- R1: In capture mode, a qualifying edge stores the selected time-base bus into the data register. The bus select bit (control bit 6) picks the bus: 0 selects bus 0 and 1 selects bus 1.
- R2: The level bit (control bit 1) picks the capture edge: 1 means rising and 0 means falling. An edge of the other polarity leaves the data register unchanged.
- R3: In capture mode the status bit IN (control bit 5) reads the synchronized level of the input pin.
- R4: A capture sets the flag (control bit 4). A later capture while the flag is set still overwrites the data register, and the flag stays set.
- R5: In capture mode the output flip-flop follows the level bit. After a switch to compare mode, the pin keeps that preloaded value until a match or a force occurs.
- R6: In compare mode (control bit 0 = 1), equality of the data register and the selected bus loads the level bit into the output flip-flop on the next edge and sets the flag. A match while the flag is already set still updates the output.
- R7: The interrupt output is 1 exactly when the flag is set and the interrupt enable bit (control bit 2) is 1.
- R8: In compare mode, writing 1 to the force bit (control bit 3) loads the level bit into the output flip-flop and leaves the flag unchanged. If a genuine match happens in the same cycle, the flag is set.
- R9: In compare mode, IN reads the output flip-flop and not the pin input.
- R10: Writing the control register with the flag bit at 0 clears the flag, and writing it at 1 leaves the flag as it is. A set event in the same cycle as a clear wins.
- R11: After reset the channel is in capture mode, the flag, interrupt enable, level and bus select are 0, and the output pin and interrupt request are 0.
- R12: wr_sel and rd_sel select the register: 0 is the data register and 1 is the control register. Readback is registered, so it shows the state from before the sampling edge. The force bit always reads 0, and the unused control bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb0_i | input | 16 | Time-base bus 0 |
| tb1_i | input | 16 | Time-base bus 1 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 data, 1 control |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read target: 0 data, 1 control |
| rd_data | output | 16 | Registered read data |
| pin_in | input | 1 | Asynchronous capture input pin |
| pin_out | output | 1 | Output flip-flop value |
| irq | output | 1 | Interrupt request |

## Verification
A wrong synchronizer depth or a wrong edge polarity shows up as a wrong data-register value or a missing flag. This can be seen on the read port a few cycles after the pin toggles. A faulty output flip-flop path, either a stale preload or a force that also sets the flag, shows on pin_out one edge after the match or the write. A faulty flag path shows on the read port and on irq in the cycle that follows. Random compare rounds against a bench-computed expected pin level and flag catch mismatches in bus selection and in level transfer.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic {
    MODE_CAP = 1'b0,
    MODE_CMP = 1'b1
  } chan_mode_e;

  // control register bit positions
  localparam int CB_MODE  = 0;
  localparam int CB_LVL   = 1;
  localparam int CB_IEN   = 2;
  localparam int CB_FORCE = 3;
  localparam int CB_FLAG  = 4;
  localparam int CB_IN    = 5;
  localparam int CB_SEL   = 6;
  localparam int CTRL_BITS = 7;
endpackage

// File: rtl/tcc_insync.sv
module tcc_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

  // R2: a detected edge is a single-cycle pulse
  a_r2_rise_single: assert property (@(posedge clk) disable iff (rst) rise_o |=> !rise_o);
  a_r2_fall_single: assert property (@(posedge clk) disable iff (rst) fall_o |=> !fall_o);
endmodule

// File: rtl/tcc_flag.sv
module tcc_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic ien_nxt_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, irq_q, flag_d;

  assign flag_d = set_i | (flag_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & ien_nxt_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  a_r4_set_sticks:  assert property (@(posedge clk) disable iff (rst) set_i |=> flag_o);
  a_r10_clear_works: assert property (@(posedge clk) disable iff (rst) (clr_i && !set_i) |=> !flag_o);
  a_r10_hold:       assert property (@(posedge clk) disable iff (rst) (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/tcc_chan.sv
module tcc_chan #(
  parameter int TB_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TB_W-1:0] tb0_i,
  input  logic [TB_W-1:0] tb1_i,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [TB_W-1:0] wr_data,
  input  logic            rd_sel,
  output logic [TB_W-1:0] rd_data,
  input  logic            pin_in,
  output logic            pin_out,
  output logic            irq
);
  import tcc_pkg::*;

  chan_mode_e      mode_q;
  logic            lvl_q, ien_q, sel_q, out_q;
  logic [TB_W-1:0] data_q, rd_q, tb_cur, ctrl_view;
  logic            sync_lvl, rise, fall;
  logic            wr_ctl, wr_dat, cap_evt, match, force_stb;
  logic            flag_set, flag_clr, ien_d, flag, in_bit;

  tcc_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_in),
    .level_o(sync_lvl), .rise_o(rise), .fall_o(fall)
  );

  assign tb_cur    = sel_q ? tb1_i : tb0_i;
  assign wr_ctl    = wr_en & wr_sel;
  assign wr_dat    = wr_en & ~wr_sel;
  assign cap_evt   = (mode_q == MODE_CAP) & (lvl_q ? rise : fall);
  assign match     = (mode_q == MODE_CMP) & (data_q == tb_cur);
  assign force_stb = wr_ctl & wr_data[CB_FORCE] & (mode_q == MODE_CMP);
  assign flag_set  = cap_evt | match;
  assign flag_clr  = wr_ctl & ~wr_data[CB_FLAG];
  assign ien_d     = wr_ctl ? wr_data[CB_IEN] : ien_q;

  tcc_flag u_flag (
    .clk(clk), .rst(rst), .set_i(flag_set), .clr_i(flag_clr),
    .ien_nxt_i(ien_d), .flag_o(flag), .irq_o(irq)
  );

  // data register: capture has priority over a software write
  always_ff @(posedge clk) begin
    if (rst)          data_q <= '0;
    else if (cap_evt) data_q <= tb_cur;
    else if (wr_dat)  data_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_CAP;
      lvl_q  <= 1'b0;
      ien_q  <= 1'b0;
      sel_q  <= 1'b0;
    end else if (wr_ctl) begin
      mode_q <= chan_mode_e'(wr_data[CB_MODE]);
      lvl_q  <= wr_data[CB_LVL];
      ien_q  <= wr_data[CB_IEN];
      sel_q  <= wr_data[CB_SEL];
    end
  end

  // output flip-flop: preloaded in capture mode, event-loaded in compare mode
  always_ff @(posedge clk) begin
    if (rst)                      out_q <= 1'b0;
    else if (mode_q == MODE_CAP)  out_q <= lvl_q;
    else if (match || force_stb)  out_q <= lvl_q;
  end

  assign in_bit = (mode_q == MODE_CMP) ? out_q : sync_lvl;

  always_comb begin
    ctrl_view           = '0;
    ctrl_view[CB_MODE]  = mode_q;
    ctrl_view[CB_LVL]   = lvl_q;
    ctrl_view[CB_IEN]   = ien_q;
    ctrl_view[CB_FLAG]  = flag;
    ctrl_view[CB_IN]    = in_bit;
    ctrl_view[CB_SEL]   = sel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_sel ? ctrl_view : data_q;
  end

  assign rd_data = rd_q;
  assign pin_out = out_q;

  a_r1_capture_loads: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> data_q == $past(tb_cur));
  a_r5_preload: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_CAP) |=> pin_out == $past(lvl_q));
  a_r6_match_drives: assert property (@(posedge clk) disable iff (rst)
    match |=> pin_out == $past(lvl_q));
  a_r8_force_drives: assert property (@(posedge clk) disable iff (rst)
    force_stb |=> pin_out == $past(lvl_q));
  a_r8_force_no_flag: assert property (@(posedge clk) disable iff (rst)
    (force_stb && !flag_set && !flag && !cap_evt) |=> !flag);
  a_r7_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq == (flag & ien_q));
endmodule

// File: tb/tcc_chan_tb.sv
`timescale 1ns/1ps
module tcc_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] tb0 = '0, tb1 = '0, wdata = '0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, pin = 1'b0;
  logic [15:0] rdata;
  logic        pout, irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  tcc_chan dut_i (
    .clk(clk), .rst(rst), .tb0_i(tb0), .tb1_i(tb1),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wdata),
    .rd_sel(rd_sel), .rd_data(rdata),
    .pin_in(pin), .pin_out(pout), .irq(irq)
  );

  function automatic logic [15:0] ctl(input logic mode, lvl, ien, frc, flg, sel);
    ctl = '0;
    ctl[0] = mode; ctl[1] = lvl; ctl[2] = ien; ctl[3] = frc; ctl[4] = flg; ctl[6] = sel;
  endfunction

  function automatic logic exp_pin(input logic hit, lvl, prev);
    exp_pin = hit ? lvl : prev;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    @(negedge clk); rd_sel = sel;
    @(posedge clk); #1 v = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, a, b, c, d;
    logic prev;
    void'($urandom(32'd24680));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R11 reset state
    rd(1'b1, v); chk("R11 ctrl", v, 16'h0000);
    chk("R11 pin_out", {15'd0, pout}, 16'd0);
    chk("R11 irq", {15'd0, irq}, 16'd0);

    // R1/R2 rising capture on bus 0
    a = 16'($urandom); b = a ^ 16'h5a5a;
    wr(1'b1, ctl(0,1,0,0,0,0));
    @(negedge clk); tb0 = a; pin = 1'b1;
    settle(5);
    rd(1'b0, v); chk("R1 capture bus0", v, a);
    rd(1'b1, v); chk("R4 flag after capture", {15'd0, v[4]}, 16'd1);
    chk("R3 IN high", {15'd0, v[5]}, 16'd1);
    // R2 opposite edge ignored
    @(negedge clk); tb0 = b; pin = 1'b0;
    settle(5);
    rd(1'b0, v); chk("R2 falling ignored", v, a);
    rd(1'b1, v); chk("R3 IN low", {15'd0, v[5]}, 16'd0);
    // R4 overwrite while flag set
    @(negedge clk); pin = 1'b1;
    settle(5);
    rd(1'b0, v); chk("R4 overwrite", v, b);
    rd(1'b1, v); chk("R4 flag stays", {15'd0, v[4]}, 16'd1);

    // R1/R2 falling capture on bus 1
    c = 16'($urandom); d = ~c;
    wr(1'b1, ctl(0,0,0,0,0,1));
    rd(1'b1, v); chk("R10 flag cleared", {15'd0, v[4]}, 16'd0);
    @(negedge clk); tb1 = c; tb0 = d; pin = 1'b0;
    settle(5);
    rd(1'b0, v); chk("R1 capture bus1 falling", v, c);

    // R5 preload then switch to compare
    @(negedge clk); tb0 = 16'h0000; tb1 = 16'h0000;
    wr(1'b0, 16'h1234);
    rd(1'b0, v); chk("R12 data write", v, 16'h1234);
    wr(1'b1, ctl(0,1,0,0,0,0));
    settle(1);
    chk("R5 preload", {15'd0, pout}, 16'd1);
    wr(1'b1, ctl(1,0,0,0,0,0));
    settle(2);
    chk("R5 kept after switch", {15'd0, pout}, 16'd1);
    rd(1'b1, v); chk("R9 IN shows flop", {15'd0, v[5]}, 16'd1);

    // R6 match
    @(negedge clk); tb0 = 16'h1234;
    @(posedge clk); #1 chk("R6 match drives", {15'd0, pout}, 16'd0);
    @(negedge clk); tb0 = 16'h0000;
    rd(1'b1, v); chk("R6 flag set", {15'd0, v[4]}, 16'd1);
    chk("R9 IN follows flop", {15'd0, v[5]}, 16'd0);
    wr(1'b1, ctl(1,1,0,0,1,0));
    @(negedge clk); tb0 = 16'h1234;
    @(posedge clk); #1 chk("R6 match while flag set", {15'd0, pout}, 16'd1);
    @(negedge clk); tb0 = 16'h0000;

    // R7 interrupt
    wr(1'b1, ctl(1,1,1,0,1,0));
    chk("R7 irq on", {15'd0, irq}, 16'd1);
    wr(1'b1, ctl(1,1,1,0,0,0));
    chk("R7 irq off", {15'd0, irq}, 16'd0);

    // R8 force without flag
    wr(1'b1, ctl(1,0,1,0,0,0));
    chk("R8 no change before force", {15'd0, pout}, 16'd1);
    wr(1'b1, ctl(1,0,1,1,0,0));
    chk("R8 force drives", {15'd0, pout}, 16'd0);
    rd(1'b1, v); chk("R8 force leaves flag", {15'd0, v[4]}, 16'd0);
    chk("R12 force reads 0", {15'd0, v[3]}, 16'd0);
    chk("R7 irq stays low", {15'd0, irq}, 16'd0);
    // R8 + R10 force coinciding with match, clear in same write
    wr(1'b1, ctl(1,1,1,0,0,0));
    @(negedge clk); wr_en = 1'b1; wr_sel = 1'b1; wdata = ctl(1,1,1,1,0,0); tb0 = 16'h1234;
    @(negedge clk); wr_en = 1'b0;
    rd(1'b1, v); chk("R8 match with force sets flag", {15'd0, v[4]}, 16'd1);
    wr(1'b1, ctl(1,1,1,0,0,0));
    rd(1'b1, v); chk("R10 set beats clear", {15'd0, v[4]}, 16'd1);
    chk("R7 irq with flag", {15'd0, irq}, 16'd1);
    @(negedge clk); tb0 = 16'h0000;

    // random compare rounds
    for (int i = 0; i < 40; i++) begin
      logic [15:0] dv;
      logic lv, sl, hit;
      dv = 16'($urandom); lv = 1'($urandom); sl = 1'($urandom); hit = 1'($urandom);
      @(negedge clk); tb0 = dv ^ 16'h0003; tb1 = dv ^ 16'h0003;
      wr(1'b0, dv);
      wr(1'b1, ctl(1, lv, 0, 0, 0, sl));
      settle(1);
      prev = pout;
      if (hit) begin
        if (sl) tb1 = dv; else tb0 = dv;
      end
      @(posedge clk); #1
      chk("R6 random pin", {15'd0, pout}, {15'd0, exp_pin(hit, lv, prev)});
      rd(1'b1, v); chk("R6 random flag", {15'd0, v[4]}, {15'd0, hit});
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule